// File: doc/BRIEF.md
# In-Order Completion Queue

This block is a small circular queue that follows instructions from dispatch until they retire. A dispatched instruction takes the slot at the tail and stores its 8-bit tag there, with its "done" flag clear. Execution units report finished work by tag, in any order. The queue searches its live slots for that tag and marks the matching slot done.

Retirement runs strictly in program order from the head. In each cycle the head slot retires if it is done. If it retires and the slot after it is also done, that slot retires in the same cycle. No more than two slots retire per cycle.

The queue keeps free and used counts, which always reflect every dispatch and retirement of the cycle together. It raises a stall output whenever no slot is free, and refuses dispatch while that output is high. A report whose tag matches no live slot changes no slot and sets a sticky error flag.

Top module: `completion_queue`

## Requirements
- R1: After synchronous reset, used_cnt is 0, free_cnt is 6, issue_stall is 0, ret_valid is 2'b00 and tag_err is 0.
- R2: A dispatch accepted at a clock edge (disp_valid high while issue_stall is low) allocates one slot, so used_cnt rises by one and free_cnt falls by one after that edge. A dispatch presented while issue_stall is high is dropped, and its tag never retires.
- R3: issue_stall is 1 exactly when free_cnt is 0, that is, after six dispatches that have not yet retired.
- R4: Completion reports may arrive in any order, on either report port. A slot retires only after it is done and every older slot has retired, so tags leave in dispatch order.
- R5: At most two slots retire per cycle. ret_valid is 2'b01 for one retirement and 2'b11 for two, and ret_tag0 carries the older tag. A third done slot waits for a later cycle.
- R6: A report sampled at clock edge e makes its slot eligible to retire at edge e+1 at the earliest. The retirement appears on ret_valid and ret_tag0/ret_tag1 after that edge and lasts one cycle.
- R7: When a dispatch and one or two retirements happen at the same edge, used_cnt changes by the number of dispatches minus the number of retirements.
- R8: A report whose tag matches no live slot leaves every slot unchanged and sets tag_err, which stays 1 until reset. This covers a tag that was never accepted and a tag that has already retired.
- R9: Slot allocation and retirement wrap from the last of the six slots back to the first, and dispatch order is kept across the wrap.
- R10: free_cnt plus used_cnt always equals 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_tag | input | 8 | Tag of the dispatched instruction |
| cmpl_valid | input | 2 | Completion report valid, one bit per report port |
| cmpl_tag | input | 16 | Report tags; port k uses bits [8k+7:8k] |
| issue_stall | output | 1 | No free slot; dispatch is refused |
| free_cnt | output | 3 | Number of free slots |
| used_cnt | output | 3 | Number of occupied slots |
| ret_valid | output | 2 | Bit 0: one retirement this cycle; bit 1: a second one |
| ret_tag0 | output | 8 | Tag of the older retiring slot |
| ret_tag1 | output | 8 | Tag of the second retiring slot |
| tag_err | output | 1 | Sticky flag for an unmatched completion report |

## Verification
A slot whose done flag is set wrongly or lost shows up on ret_valid one edge after the head reaches it. The tag retires too early, or the queue stops retiring while used_cnt stays above zero. A head or tail pointer that slips its wrap shows on ret_tag0/ret_tag1 as a tag out of dispatch order within the few cycles of the wrap sequence. A count error shows at once as a wrong used_cnt after the edge that caused it. A stuck or dropped error flag shows on tag_err one edge after a stray report.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int CQ_DEPTH = 6;
  localparam int CQ_TAG_W = 8;
  localparam int CQ_RPT   = 2;

  // pointer step modulo the queue depth
  function automatic int wrap_add(input int p, input int n, input int depth);
    return (p + n) % depth;
  endfunction
endpackage

// File: rtl/cq_entry_array.sv
module cq_entry_array #(
  parameter int DEPTH = 6,
  parameter int TAG_W = 8,
  parameter int NRPT  = 2,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc_en,
  input  logic [PW-1:0]           alloc_idx,
  input  logic [TAG_W-1:0]        alloc_tag,
  input  logic [1:0]              rel_en,
  input  logic [PW-1:0]           rel_idx0,
  input  logic [PW-1:0]           rel_idx1,
  input  logic [NRPT-1:0]         rpt_valid,
  input  logic [NRPT*TAG_W-1:0]   rpt_tag,
  output logic [DEPTH-1:0]        ent_vld,
  output logic [DEPTH-1:0]        ent_done,
  output logic [DEPTH*TAG_W-1:0]  ent_tag,
  output logic [NRPT-1:0]         rpt_miss
);
  logic [NRPT-1:0][DEPTH-1:0] match;
  logic [DEPTH-1:0]           hit_any;

  for (genvar k = 0; k < NRPT; k++) begin : g_rpt
    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
      assign match[k][e] = ent_vld[e] && rpt_valid[k] &&
                           (rpt_tag[k*TAG_W +: TAG_W] == ent_tag[e*TAG_W +: TAG_W]);
    end
    assign rpt_miss[k] = rpt_valid[k] && !(|match[k]);
  end

  always_comb begin
    hit_any = '0;
    for (int k = 0; k < NRPT; k++) hit_any = hit_any | match[k];
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic             v_q;
    logic             d_q;
    logic [TAG_W-1:0] t_q;
    logic             rel_here;
    logic             alloc_here;

    assign rel_here   = (rel_en[0] && rel_idx0 == PW'(e)) ||
                        (rel_en[1] && rel_idx1 == PW'(e));
    assign alloc_here = alloc_en && alloc_idx == PW'(e);

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        t_q <= '0;
      end else if (rel_here) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (alloc_here) begin
        v_q <= 1'b1;
        d_q <= 1'b0;
        t_q <= alloc_tag;
      end else if (hit_any[e]) begin
        d_q <= 1'b1;
      end
    end

    assign ent_vld[e]                 = v_q;
    assign ent_done[e]                = d_q;
    assign ent_tag[e*TAG_W +: TAG_W]  = t_q;
  end
endmodule

// File: rtl/cq_retire_sel.sv
module cq_retire_sel #(
  parameter int DEPTH = 6,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic [PW-1:0]    head,
  input  logic [DEPTH-1:0] ent_vld,
  input  logic [DEPTH-1:0] ent_done,
  output logic [1:0]       ret_en,
  output logic [PW-1:0]    ret_idx0,
  output logic [PW-1:0]    ret_idx1
);
  logic first_ok;
  logic second_ok;

  assign ret_idx0  = head;
  assign ret_idx1  = (head == PW'(DEPTH - 1)) ? '0 : head + PW'(1);
  assign first_ok  = ent_vld[ret_idx0] && ent_done[ret_idx0];
  assign second_ok = first_ok && ent_vld[ret_idx1] && ent_done[ret_idx1];
  assign ret_en    = {second_ok, first_ok};
endmodule

// File: rtl/cq_counters.sv
module cq_counters #(
  parameter int DEPTH = 6,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_en,
  input  logic [1:0]    ret_en,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] used,
  output logic [CW-1:0] free,
  output logic          full
);
  import cq_pkg::*;

  logic [CW-1:0] used_nx;
  int            n_ret;

  always_comb begin
    n_ret   = int'(ret_en[0]) + int'(ret_en[1]);
    used_nx = used + CW'(alloc_en) - CW'(ret_en[0]) - CW'(ret_en[1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      used <= '0;
      free <= CW'(DEPTH);
      full <= 1'b0;
    end else begin
      head <= PW'(wrap_add(int'(head), n_ret, DEPTH));
      if (alloc_en) tail <= PW'(wrap_add(int'(tail), 1, DEPTH));
      used <= used_nx;
      free <= CW'(DEPTH) - used_nx;
      full <= (used_nx == CW'(DEPTH));
    end
  end
endmodule

// File: rtl/completion_queue.sv
module completion_queue #(
  parameter int DEPTH = cq_pkg::CQ_DEPTH,
  parameter int TAG_W = cq_pkg::CQ_TAG_W,
  parameter int NRPT  = cq_pkg::CQ_RPT,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  disp_valid,
  input  logic [TAG_W-1:0]      disp_tag,
  input  logic [NRPT-1:0]       cmpl_valid,
  input  logic [NRPT*TAG_W-1:0] cmpl_tag,
  output logic                  issue_stall,
  output logic [CW-1:0]         free_cnt,
  output logic [CW-1:0]         used_cnt,
  output logic [1:0]            ret_valid,
  output logic [TAG_W-1:0]      ret_tag0,
  output logic [TAG_W-1:0]      ret_tag1,
  output logic                  tag_err
);
  logic                   accept;
  logic [PW-1:0]          head;
  logic [PW-1:0]          tail;
  logic [DEPTH-1:0]       ent_vld;
  logic [DEPTH-1:0]       ent_done;
  logic [DEPTH*TAG_W-1:0] ent_tag;
  logic [NRPT-1:0]        rpt_miss;
  logic [1:0]             ret_en;
  logic [PW-1:0]          ret_idx0;
  logic [PW-1:0]          ret_idx1;

  assign accept = disp_valid && !issue_stall;

  cq_entry_array #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NRPT(NRPT)) u_array (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (accept),
    .alloc_idx (tail),
    .alloc_tag (disp_tag),
    .rel_en    (ret_en),
    .rel_idx0  (ret_idx0),
    .rel_idx1  (ret_idx1),
    .rpt_valid (cmpl_valid),
    .rpt_tag   (cmpl_tag),
    .ent_vld   (ent_vld),
    .ent_done  (ent_done),
    .ent_tag   (ent_tag),
    .rpt_miss  (rpt_miss)
  );

  cq_retire_sel #(.DEPTH(DEPTH)) u_sel (
    .head     (head),
    .ent_vld  (ent_vld),
    .ent_done (ent_done),
    .ret_en   (ret_en),
    .ret_idx0 (ret_idx0),
    .ret_idx1 (ret_idx1)
  );

  cq_counters #(.DEPTH(DEPTH)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .alloc_en (accept),
    .ret_en   (ret_en),
    .head     (head),
    .tail     (tail),
    .used     (used_cnt),
    .free     (free_cnt),
    .full     (issue_stall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid <= 2'b00;
      ret_tag0  <= '0;
      ret_tag1  <= '0;
      tag_err   <= 1'b0;
    end else begin
      ret_valid <= ret_en;
      ret_tag0  <= ent_tag[ret_idx0*TAG_W +: TAG_W];
      ret_tag1  <= ent_tag[ret_idx1*TAG_W +: TAG_W];
      tag_err   <= tag_err || (|rpt_miss);
    end
  end
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int DEPTH = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          disp_valid,
  input logic          issue_stall,
  input logic [CW-1:0] free_cnt,
  input logic [CW-1:0] used_cnt,
  input logic [1:0]    ret_valid,
  input logic          tag_err
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (used_cnt == '0 && free_cnt == CW'(DEPTH) && !issue_stall &&
             ret_valid == 2'b00 && !tag_err));

  // R10
  count_sum_chk: assert property (@(posedge clk) disable iff (rst)
    int'(free_cnt) + int'(used_cnt) == DEPTH);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(used_cnt) <= DEPTH);

  // R3
  full_flag_chk: assert property (@(posedge clk) disable iff (rst)
    issue_stall == (free_cnt == '0));

  // R5
  retire_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ret_valid[1] |-> ret_valid[0]);

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> int'(used_cnt) == int'($past(used_cnt)) +
                               int'($past(disp_valid && !issue_stall)) -
                               int'(ret_valid[0]) - int'(ret_valid[1]));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tag_err |=> tag_err);
endmodule

bind completion_queue cq_checker #(.DEPTH(DEPTH)) u_cq_checker (
  .clk         (clk),
  .rst         (rst),
  .disp_valid  (disp_valid),
  .issue_stall (issue_stall),
  .free_cnt    (free_cnt),
  .used_cnt    (used_cnt),
  .ret_valid   (ret_valid),
  .tag_err     (tag_err)
);

// File: tb/test_completion_queue.sv
`timescale 1ns/1ps
module test_completion_queue;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        disp_valid = 1'b0;
  logic [7:0]  disp_tag = '0;
  logic [1:0]  cmpl_valid = '0;
  logic [15:0] cmpl_tag = '0;
  logic        issue_stall;
  logic [2:0]  free_cnt;
  logic [2:0]  used_cnt;
  logic [1:0]  ret_valid;
  logic [7:0]  ret_tag0;
  logic [7:0]  ret_tag1;
  logic        tag_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  completion_queue i_completion_queue (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .issue_stall(issue_stall),
    .free_cnt(free_cnt), .used_cnt(used_cnt), .ret_valid(ret_valid),
    .ret_tag0(ret_tag0), .ret_tag1(ret_tag1), .tag_err(tag_err)
  );

  typedef struct packed {
    logic       dv;
    logic [7:0] dt;
    logic       c0v;
    logic [7:0] c0t;
    logic       c1v;
    logic [7:0] c1t;
    logic [2:0] used;
    logic       full;
    logic [1:0] rv;
    logic [7:0] t0;
    logic [7:0] t1;
    logic       err;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 24;
  // one row per clock edge: inputs, then the expected outputs after the edge
  localparam vec_t VT [NV] = '{
    '{1'b1,8'h10, 1'b0,8'h00, 1'b0,8'h00, 3'd1,1'b0,2'b00,8'h00,8'h00,1'b0,4'd2},  // R2
    '{1'b1,8'h11, 1'b0,8'h00, 1'b0,8'h00, 3'd2,1'b0,2'b00,8'h00,8'h00,1'b0,4'd2},  // R2
    '{1'b1,8'h12, 1'b1,8'h11, 1'b0,8'h00, 3'd3,1'b0,2'b00,8'h00,8'h00,1'b0,4'd4},  // R4 younger first
    '{1'b0,8'h00, 1'b1,8'h10, 1'b0,8'h00, 3'd3,1'b0,2'b00,8'h00,8'h00,1'b0,4'd4},  // R4 head not yet done
    '{1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00, 3'd1,1'b0,2'b11,8'h10,8'h11,1'b0,4'd5},  // R5 pair
    '{1'b1,8'h13, 1'b1,8'h12, 1'b0,8'h00, 3'd2,1'b0,2'b00,8'h00,8'h00,1'b0,4'd7},  // R7
    '{1'b1,8'h14, 1'b1,8'h13, 1'b0,8'h00, 3'd2,1'b0,2'b01,8'h12,8'h00,1'b0,4'd7},  // R7 disp+retire
    '{1'b1,8'h15, 1'b1,8'h14, 1'b0,8'h00, 3'd2,1'b0,2'b01,8'h13,8'h00,1'b0,4'd7},  // R7
    '{1'b1,8'h16, 1'b1,8'h15, 1'b0,8'h00, 3'd2,1'b0,2'b01,8'h14,8'h00,1'b0,4'd9},  // R9 tail wraps
    '{1'b0,8'h00, 1'b1,8'h16, 1'b0,8'h00, 3'd1,1'b0,2'b01,8'h15,8'h00,1'b0,4'd9},  // R9
    '{1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00, 3'd0,1'b0,2'b01,8'h16,8'h00,1'b0,4'd9},  // R9 head wraps
    '{1'b1,8'h20, 1'b0,8'h00, 1'b0,8'h00, 3'd1,1'b0,2'b00,8'h00,8'h00,1'b0,4'd2},  // R2
    '{1'b1,8'h21, 1'b0,8'h00, 1'b0,8'h00, 3'd2,1'b0,2'b00,8'h00,8'h00,1'b0,4'd2},
    '{1'b1,8'h22, 1'b0,8'h00, 1'b0,8'h00, 3'd3,1'b0,2'b00,8'h00,8'h00,1'b0,4'd2},
    '{1'b1,8'h23, 1'b0,8'h00, 1'b0,8'h00, 3'd4,1'b0,2'b00,8'h00,8'h00,1'b0,4'd2},
    '{1'b1,8'h24, 1'b0,8'h00, 1'b0,8'h00, 3'd5,1'b0,2'b00,8'h00,8'h00,1'b0,4'd2},
    '{1'b1,8'h25, 1'b0,8'h00, 1'b0,8'h00, 3'd6,1'b1,2'b00,8'h00,8'h00,1'b0,4'd3},  // R3 full
    '{1'b1,8'h26, 1'b0,8'h00, 1'b0,8'h00, 3'd6,1'b1,2'b00,8'h00,8'h00,1'b0,4'd3},  // R3 refused
    '{1'b0,8'h00, 1'b1,8'h22, 1'b1,8'h20, 3'd6,1'b1,2'b00,8'h00,8'h00,1'b0,4'd4},  // R4 two ports
    '{1'b0,8'h00, 1'b1,8'h21, 1'b1,8'h23, 3'd5,1'b0,2'b01,8'h20,8'h00,1'b0,4'd6},  // R6 0x21 waits
    '{1'b0,8'h00, 1'b1,8'h24, 1'b1,8'h25, 3'd3,1'b0,2'b11,8'h21,8'h22,1'b0,4'd5},  // R5 third waits
    '{1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00, 3'd1,1'b0,2'b11,8'h23,8'h24,1'b0,4'd5},  // R5
    '{1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00, 3'd0,1'b0,2'b01,8'h25,8'h00,1'b0,4'd4},  // R4
    '{1'b0,8'h00, 1'b1,8'h26, 1'b0,8'h00, 3'd0,1'b0,2'b00,8'h00,8'h00,1'b1,4'd8}   // R8 refused tag
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    disp_valid = 1'b0;
    cmpl_valid = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    string rq;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", "used", int'(used_cnt), 0);
    chk("R1", "free", int'(free_cnt), 6);
    chk("R1", "stall", int'(issue_stall), 0);
    chk("R1", "ret_valid", int'(ret_valid), 0);
    chk("R1", "err", int'(tag_err), 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      disp_valid = VT[i].dv;
      disp_tag   = VT[i].dt;
      cmpl_valid = {VT[i].c1v, VT[i].c0v};
      cmpl_tag   = {VT[i].c1t, VT[i].c0t};
      @(posedge clk);
      #1;
      rq = $sformatf("R%0d step%0d", VT[i].req, i + 1);
      chk(rq, "used", int'(used_cnt), int'(VT[i].used));
      chk({rq, " R10"}, "free", int'(free_cnt), 6 - int'(VT[i].used));
      chk(rq, "stall", int'(issue_stall), int'(VT[i].full));
      chk(rq, "ret_valid", int'(ret_valid), int'(VT[i].rv));
      if (VT[i].rv[0]) chk(rq, "ret_tag0", int'(ret_tag0), int'(VT[i].t0));
      if (VT[i].rv[1]) chk(rq, "ret_tag1", int'(ret_tag1), int'(VT[i].t1));
      chk(rq, "err", int'(tag_err), int'(VT[i].err));
    end

    // R1 reset clears the sticky error and the counts
    @(negedge clk); idle_inputs(); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", "err after reset", int'(tag_err), 0);
    chk("R1", "used after reset", int'(used_cnt), 0);

    // R8 stray tag while 0x40 is live: no effect on that slot
    @(negedge clk); disp_valid = 1'b1; disp_tag = 8'h40;
    @(posedge clk); #1;
    chk("R2", "used", int'(used_cnt), 1);
    @(negedge clk); idle_inputs(); cmpl_valid = 2'b01; cmpl_tag = 16'h0041;
    @(posedge clk); #1;
    chk("R8", "err", int'(tag_err), 1);
    @(negedge clk); idle_inputs();
    @(posedge clk); #1;
    chk("R8", "no retire from stray", int'(ret_valid), 0);
    chk("R8", "used", int'(used_cnt), 1);

    // R6 report of 0x40 on port 1, retirement one edge later
    @(negedge clk); cmpl_valid = 2'b10; cmpl_tag = 16'h4000;
    @(posedge clk); #1;
    chk("R6", "ret_valid same edge", int'(ret_valid), 0);
    @(negedge clk); idle_inputs();
    @(posedge clk); #1;
    chk("R6", "ret_valid next edge", int'(ret_valid), 1);
    chk("R6", "ret_tag0", int'(ret_tag0), 8'h40);
    chk("R6", "used", int'(used_cnt), 0);
    @(posedge clk); #1;
    chk("R6", "single-cycle pulse", int'(ret_valid), 0);
    chk("R8", "err stays", int'(tag_err), 1);

    finish_run();
  end
endmodule